// File: doc/BRIEF.md
# Dual Comparator Change-Flag and Interrupt Controller

This block sits between two analog comparators and the processor's interrupt logic. It brings each raw comparator output into the clock domain, gates it with a per-channel enable, and latches a sticky change flag whenever the gated output moves in either direction. A disabled channel drives its gated output high. Switching off a channel whose output was low therefore produces a rising edge, and that edge sets its flag like any other change.

Both flags feed one shared interrupt request. The request is qualified by a local comparator interrupt enable and by a global interrupt enable. Software must read both flags to learn which channel fired. A power-mode input lets the block keep working in the light sleep modes, where a flagged change raises a wake-up request. In the deepest sleep mode the same input forces both channels off without touching their enable bits.

Software reaches the enables and flags through per-channel set, clear and write-one-to-clear strobes. It reads their state back on output ports.

Top module: `cmp_flag_ctrl`

## Requirements
- R1: A change of a channel's gated output, in either direction, sets that channel's flag. A raw input change reaches the gated output and the flag on the third rising clock edge after it is applied: two synchronizer edges plus the output register.
- R2: A one-cycle pulse on a channel's flag-clear strobe clears its flag. If a change of that channel's output falls on the same edge, the flag stays set.
- R3: `irq_o` is high exactly when the comparator interrupt enable and `gie_i` are both high and at least one flag is set. It follows `gie_i` combinationally.
- R4: While a channel is inactive, its gated output is high whatever its raw input is.
- R5: Clearing a channel's enable while its gated output is low drives that output high one edge after the enable clears, and sets its flag on the same edge.
- R6: With `pwr_mode_i` = 2'b11 (deepest sleep), both channels are inactive and their gated outputs go high. Their enable bits keep their values.
- R7: `wake_o` is high exactly when the comparator interrupt enable is high, at least one flag is set, and `pwr_mode_i` is 2'b01 (idle) or 2'b10 (power-down). It is low for 2'b00 (run) and 2'b11. `wake_o` does not depend on `gie_i`.
- R8: After reset, both enables are low, both flags are low, the interrupt enable is low, both gated outputs are high and `irq_o` is low. The reset-time forcing sets no flag. The internal reset is released two clock edges after `rst_n` rises.
- R9: The enable set and clear strobes take effect on the next edge. When a set strobe and a clear strobe for the same enable arrive together, the clear wins. This holds for the channel enables and for the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw_i | input | NUM_CH | Raw comparator outputs, asynchronous |
| pwr_mode_i | input | 2 | 00 run, 01 idle, 10 power-down, 11 deepest sleep |
| gie_i | input | 1 | Global interrupt enable |
| ch_en_set_i | input | NUM_CH | Per-channel enable set strobes |
| ch_en_clr_i | input | NUM_CH | Per-channel enable clear strobes |
| flag_clr_i | input | NUM_CH | Per-channel write-one-to-clear flag strobes |
| irq_en_set_i | input | 1 | Comparator interrupt enable set strobe |
| irq_en_clr_i | input | 1 | Comparator interrupt enable clear strobe |
| ch_en_o | output | NUM_CH | Channel enable bits |
| cmp_out_o | output | NUM_CH | Gated comparator outputs |
| flag_o | output | NUM_CH | Change flags |
| irq_en_o | output | 1 | Comparator interrupt enable bit |
| irq_o | output | 1 | Shared interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
The bench targets the case where a flag clear meets a fresh output change on the same edge. A design that gives the clear priority would lose that event and report no interrupt.

It also disables a channel while its output is low. A design that gates the raw input without forcing the output high, or that does not edge-detect the forced value, would leave the flag clear.

It enters deepest sleep with a channel enabled. A design that clears the enable bit instead of masking it would not resume that channel on waking.

Finally, it checks the exact cycle of flag arrival and checks `wake_o` in every power mode. An extra or missing synchronizer stage shows up as a shifted flag. Wake-up leaking into run or deepest sleep shows up directly on `wake_o`.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_IDLE  = 2'b01,
    PM_PDOWN = 2'b10,
    PM_DEEP  = 2'b11
  } pmode_e;

  // Modes in which a flagged change may wake the processor
  function automatic logic pm_can_wake(pmode_e m);
    return (m == PM_IDLE) || (m == PM_PDOWN);
  endfunction

endpackage

// File: rtl/cmpf_sync.sv
// Multi-stage flop chain used both for asynchronous inputs and for reset release
module cmpf_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_i;
    for (int k = 1; k < STAGES; k++) begin
      stage_d[k] = stage_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) begin
        stage_q[k] <= {WIDTH{RST_VAL}};
      end
    end else begin
      for (int k = 0; k < STAGES; k++) begin
        stage_q[k] <= stage_d[k];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/cmpf_channel.sv
// One comparator channel: enable bit, gated output register, sticky change flag
module cmpf_channel (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic force_off_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  input  logic flag_clr_i,
  output logic en_o,
  output logic out_o,
  output logic flag_o
);

  logic en_q, en_d, en_ce;
  logic out_q, out_d;
  logic flag_q, flag_d, flag_ce;
  logic active, change;

  always_comb begin
    en_ce   = en_set_i | en_clr_i;
    en_d    = ~en_clr_i;                 // clear strobe wins over set
    active  = en_q & ~force_off_i;
    out_d   = active ? sync_i : 1'b1;    // inactive channel parks high
    change  = out_d ^ out_q;
    flag_ce = change | flag_clr_i;
    flag_d  = change;                    // a new change beats the clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      out_q  <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      if (en_ce)   en_q   <= en_d;
      if (change)  out_q  <= out_d;
      if (flag_ce) flag_q <= flag_d;
    end
  end

  assign en_o   = en_q;
  assign out_o  = out_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/cmpf_irq.sv
// Shared interrupt enable register and request combining
module cmpf_irq
  import cmpf_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] flag_i,
  input  logic              gie_i,
  input  logic              ien_set_i,
  input  logic              ien_clr_i,
  input  pmode_e            pmode_i,
  output logic              ien_o,
  output logic              irq_o,
  output logic              wake_o
);

  logic ien_q, ien_d, ien_ce;
  logic any_flag;

  always_comb begin
    ien_ce   = ien_set_i | ien_clr_i;
    ien_d    = ~ien_clr_i;
    any_flag = |flag_i;
    irq_o    = ien_q & gie_i & any_flag;
    // combinational path so wake-up does not need the main clock
    wake_o   = ien_q & any_flag & pm_can_wake(pmode_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
    end else if (ien_ce) begin
      ien_q <= ien_d;
    end
  end

  assign ien_o = ien_q;

endmodule

// File: rtl/cmp_flag_ctrl.sv
module cmp_flag_ctrl
  import cmpf_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cmp_raw_i,
  input  logic [1:0]        pwr_mode_i,
  input  logic              gie_i,
  input  logic [NUM_CH-1:0] ch_en_set_i,
  input  logic [NUM_CH-1:0] ch_en_clr_i,
  input  logic [NUM_CH-1:0] flag_clr_i,
  input  logic              irq_en_set_i,
  input  logic              irq_en_clr_i,
  output logic [NUM_CH-1:0] ch_en_o,
  output logic [NUM_CH-1:0] cmp_out_o,
  output logic [NUM_CH-1:0] flag_o,
  output logic              irq_en_o,
  output logic              irq_o,
  output logic              wake_o
);

  logic              rst_int_n;
  logic [NUM_CH-1:0] raw_sync;
  pmode_e            pmode;
  logic              force_off;

  assign pmode     = pmode_e'(pwr_mode_i);
  assign force_off = (pmode == PM_DEEP);

  // asserted asynchronously, released on a clock edge
  cmpf_sync #(.WIDTH(1), .STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_int_n)
  );

  cmpf_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_raw_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (cmp_raw_i),
    .q_o   (raw_sync)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    cmpf_channel u_ch (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .sync_i      (raw_sync[i]),
      .force_off_i (force_off),
      .en_set_i    (ch_en_set_i[i]),
      .en_clr_i    (ch_en_clr_i[i]),
      .flag_clr_i  (flag_clr_i[i]),
      .en_o        (ch_en_o[i]),
      .out_o       (cmp_out_o[i]),
      .flag_o      (flag_o[i])
    );
  end

  cmpf_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .flag_i    (flag_o),
    .gie_i     (gie_i),
    .ien_set_i (irq_en_set_i),
    .ien_clr_i (irq_en_clr_i),
    .pmode_i   (pmode),
    .ien_o     (irq_en_o),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
  );

endmodule

// File: rtl/cmp_flag_ctrl_chk.sv
module cmp_flag_ctrl_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        pwr_mode_i,
  input logic              gie_i,
  input logic [NUM_CH-1:0] ch_en_clr_i,
  input logic [NUM_CH-1:0] flag_clr_i,
  input logic [NUM_CH-1:0] ch_en_o,
  input logic [NUM_CH-1:0] cmp_out_o,
  input logic [NUM_CH-1:0] flag_o,
  input logic              irq_en_o,
  input logic              irq_o,
  input logic              wake_o
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r1_change_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_out_o[i] != $past(cmp_out_o[i])) |-> flag_o[i]);

    a_r2_clear_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o[i]) |-> $past(flag_clr_i[i]));

    a_r4_inactive_high: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en_o[i] |=> cmp_out_o[i]);

    a_r6_deep_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_mode_i == 2'b11) |=> cmp_out_o[i]);

    a_r8_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o[i]) |-> (cmp_out_o[i] != $past(cmp_out_o[i])));

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ch_en_clr_i[i]) |-> !ch_en_o[i]);
  end

  a_r3_irq_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (gie_i && irq_en_o && (|flag_o)));

  a_r7_no_wake_run_deep: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode_i == 2'b00 || pwr_mode_i == 2'b11) |-> !wake_o);

endmodule

bind cmp_flag_ctrl cmp_flag_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_mode_i  (pwr_mode_i),
  .gie_i       (gie_i),
  .ch_en_clr_i (ch_en_clr_i),
  .flag_clr_i  (flag_clr_i),
  .ch_en_o     (ch_en_o),
  .cmp_out_o   (cmp_out_o),
  .flag_o      (flag_o),
  .irq_en_o    (irq_en_o),
  .irq_o       (irq_o),
  .wake_o      (wake_o)
);

// File: tb/cmp_flag_ctrl_bench.sv
`timescale 1ns/1ps
module cmp_flag_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] raw, pm, en_set, en_clr, fclr;
  logic       gie, ien_set, ien_clr;
  logic [1:0] en_o, out_o, flag_o;
  logic       ien_o, irq_o, wake_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cmp_flag_ctrl u_cmp_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .cmp_raw_i(raw), .pwr_mode_i(pm), .gie_i(gie),
    .ch_en_set_i(en_set), .ch_en_clr_i(en_clr), .flag_clr_i(fclr),
    .irq_en_set_i(ien_set), .irq_en_clr_i(ien_clr),
    .ch_en_o(en_o), .cmp_out_o(out_o), .flag_o(flag_o),
    .irq_en_o(ien_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [1:0] m_en, m_out, m_flag;
  logic       m_ien;
  logic [1:0] m_hist[$];
  int         m_rcnt;

  task automatic m_reset();
    m_en = 2'b00; m_out = 2'b11; m_flag = 2'b00; m_ien = 1'b0;
    m_hist = '{2'b11, 2'b11};
  endtask

  initial m_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rcnt = 0;
      m_reset();
    end else if (m_rcnt < 2) begin
      m_rcnt++;
      m_reset();
    end else begin
      for (int c = 0; c < 2; c++) begin
        logic nxt;
        nxt = (m_en[c] && pm != 2'b11) ? m_hist[0][c] : 1'b1;
        if (nxt != m_out[c]) m_flag[c] = 1'b1;
        else if (fclr[c])    m_flag[c] = 1'b0;
        m_out[c] = nxt;
        if (en_clr[c])      m_en[c] = 1'b0;
        else if (en_set[c]) m_en[c] = 1'b1;
      end
      if (ien_clr)      m_ien = 1'b0;
      else if (ien_set) m_ien = 1'b1;
      m_hist.push_back(raw);
      void'(m_hist.pop_front());
    end
  end

  always @(negedge clk) begin
    chk("R4 gated out vs model", {6'd0, out_o}, {6'd0, m_out});
    chk("R1 flags vs model", {6'd0, flag_o}, {6'd0, m_flag});
    chk("R9 enables vs model", {5'd0, ien_o, en_o}, {5'd0, m_ien, m_en});
    chk("R3 irq vs model", {7'd0, irq_o}, {7'd0, m_ien & gie & (|m_flag)});
    chk("R7 wake vs model", {7'd0, wake_o},
        {7'd0, m_ien & (|m_flag) & (pm == 2'b01 || pm == 2'b10)});
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_en(input logic [1:0] s, input logic [1:0] c);
    en_set = s; en_clr = c; step(1); en_set = 2'b00; en_clr = 2'b00;
  endtask

  task automatic pulse_fclr(input logic [1:0] c);
    fclr = c; step(1); fclr = 2'b00;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; raw = 2'b11; pm = 2'b00; gie = 1'b0;
    en_set = 2'b00; en_clr = 2'b00; fclr = 2'b00; ien_set = 1'b0; ien_clr = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    // R8 reset state
    chk("R8 flags after reset", {6'd0, flag_o}, 8'h00);
    chk("R8 outputs after reset", {6'd0, out_o}, 8'h03);
    chk("R8 enables/irq after reset", {4'd0, ien_o, irq_o, en_o}, 8'h00);

    // R4 raw low while disabled
    raw = 2'b00; step(4);
    chk("R4 disabled stays high", {6'd0, out_o}, 8'h03);
    chk("R4 no flag while disabled", {6'd0, flag_o}, 8'h00);

    // R9 enable ch0, R1 falling change flags
    pulse_en(2'b01, 2'b00); step(1);
    chk("R9 ch0 enabled", {6'd0, en_o}, 8'h01);
    chk("R1 falling output", {6'd0, out_o}, 8'h02);
    chk("R1 falling change sets flag", {6'd0, flag_o}, 8'h01);

    // R2 clear
    pulse_fclr(2'b01);
    chk("R2 flag cleared", {6'd0, flag_o}, 8'h00);

    // R1 exact latency of a rising change
    raw = 2'b01; step(2);
    chk("R1 flag not yet after two edges", {6'd0, flag_o}, 8'h00);
    step(1);
    chk("R1 flag on third edge", {6'd0, flag_o}, 8'h01);
    chk("R1 rising output on third edge", {6'd0, out_o}, 8'h03);

    // R3 interrupt qualification
    ien_set = 1'b1; step(1); ien_set = 1'b0;
    chk("R3 irq blocked by global enable", {7'd0, irq_o}, 8'h00);
    gie = 1'b1; #1;
    chk("R3 irq asserted", {7'd0, irq_o}, 8'h01);
    pulse_fclr(2'b01);
    chk("R3 irq drops with flags", {7'd0, irq_o}, 8'h00);

    // R2 set beats clear on the same edge
    raw = 2'b00; step(2);
    fclr = 2'b01; step(1); fclr = 2'b00;
    chk("R2 change wins over clear", {6'd0, flag_o}, 8'h01);
    pulse_fclr(2'b01);

    // R5 disabling while low sets flag
    chk("R5 precondition out0 low", {6'd0, out_o}, 8'h02);
    pulse_en(2'b00, 2'b01); step(1);
    chk("R5 out0 forced high", {6'd0, out_o}, 8'h03);
    chk("R5 disable sets flag", {6'd0, flag_o}, 8'h01);
    pulse_fclr(2'b01);

    // R9 simultaneous set and clear
    pulse_en(2'b01, 2'b01);
    chk("R9 clear wins", {6'd0, en_o}, 8'h00);

    // R6 deepest sleep
    pulse_en(2'b10, 2'b00); step(1);
    pulse_fclr(2'b10);
    chk("R6 precondition out1 low", {6'd0, out_o}, 8'h01);
    pm = 2'b11; step(1);
    chk("R6 deep forces high", {6'd0, out_o}, 8'h03);
    chk("R6 deep keeps enable", {6'd0, en_o}, 8'h02);
    chk("R6 forced edge flags", {6'd0, flag_o}, 8'h02);
    chk("R7 no wake in deep", {7'd0, wake_o}, 8'h00);

    // R7 wake by mode
    pm = 2'b01; #1;
    chk("R7 wake in idle", {7'd0, wake_o}, 8'h01);
    pm = 2'b00; #1;
    chk("R7 no wake in run", {7'd0, wake_o}, 8'h00);
    pm = 2'b10; gie = 1'b0; #1;
    chk("R7 wake in power-down without global enable", {7'd0, wake_o}, 8'h01);
    step(2);
    ien_clr = 1'b1; step(1); ien_clr = 1'b0;
    chk("R7 no wake without interrupt enable", {7'd0, wake_o}, 8'h00);
    step(3);
    finish_run();
  end

endmodule